// File: doc/BRIEF.md
# Strided Vector Load Scheduler over Interleaved Banks

The block walks through one vector load at a time. A start command gives a base address, a stride, an element count and two timing values for the run: the access latency and the bank occupancy. Element i lives at base plus i times the stride. The low address bits pick one of several interleaved banks, and the upper bits pick a word inside that bank. The bank storage is built into the block as fixed read-only arrays. For the whole run, the block presents one element request at a time on a valid/ready pair.

Each bank has its own occupancy countdown. The ready side of the pair is high only when the bank that the pending element targets has finished its occupancy from the previous request. A request issues in a cycle where both valid and ready are high. The block counts every cycle in which the request waits on a busy bank. The word is read the chosen latency after issue and is returned with its element number. When the last word appears, a done pulse marks the end of the run.

The two timing values are independent, so a run can model three kinds of bank. In a pipelined bank the latency is longer than the occupancy, so several requests to the same bank are in flight at once. In a restore-limited bank the occupancy is longer than the latency. In a plain bank the two are equal, so each bank serves one request at a time.

Top module: `vec_bank_sched`

## Requirements
- R1: After reset, `active`, `req_valid`, `rd_valid` and `done` are 0, `stall_cnt` is 0, and `req_ready` is 1.
- R2: A start is taken when the block is idle and 1 <= `st_len` <= MAX_LEN (64). Element i, for i = 0 to len-1, has address (base + i*stride) mod 2^ADDR_W. Its bank is the low log2(NUM_BANKS) address bits, and its word inside the bank is the remaining upper bits. Exactly len words are returned.
- R3: The word stored at address A equals ((A * 40503) mod 2^32) XOR 0xC3A50F1E, cut to DATA_W bits.
- R4: Occupancy is `st_busy`, clamped to the range 1..MAX_BUSY (0 counts as 1). Issuing to a bank loads that bank's countdown with occupancy-1. The countdown falls by one each cycle, and the bank accepts again only when it reaches zero. So two issues to the same bank are at least occupancy clock edges apart.
- R5: Latency is `st_lat`, clamped to the range 1..MAX_LAT (0 counts as 1). `rd_valid` is high for the single cycle that follows the clock edge exactly latency edges after the issuing edge. When latency exceeds occupancy, several requests to one bank are in flight at once.
- R6: Words return in element order, and `rd_idx` carries the element number.
- R7: With latency equal to occupancy, each bank holds at most one outstanding request. Its next issue falls on the same edge as its previous word's return.
- R8: With occupancy greater than latency, the spacing of same-bank issues is set by the occupancy, not by the return of data.
- R9: `stall_cnt` is cleared by a taken start. It then counts every cycle in which `req_valid` is 1 and `req_ready` is 0, and saturates at its maximum.
- R10: `done` is high in the same cycle as the `rd_valid` of the last element. `active` drops on the next edge.
- R11: A start is ignored while `active` is 1, or when `st_len` is 0 or greater than 64. An ignored start changes no returned word, cycle or count.
- R12: The first request is pending in the cycle after the edge that takes the start. A request issues on every edge where its bank is free, so the block sustains one element per cycle when there are no conflicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start command strobe |
| st_base | input | ADDR_W | Address of element 0 |
| st_stride | input | ADDR_W | Address step, modulo 2^ADDR_W |
| st_len | input | LEN_W | Element count |
| st_lat | input | LAT_W | Access latency in cycles |
| st_busy | input | BUSY_W | Bank occupancy in cycles |
| active | output | 1 | Run in progress |
| req_valid | output | 1 | An element request is pending |
| req_ready | output | 1 | The pending element's bank is free |
| req_idx | output | IDX_W | Element number of the pending request |
| req_bank | output | BANK_W | Bank of the pending request |
| rd_valid | output | 1 | Returned word valid |
| rd_idx | output | IDX_W | Element number of the returned word |
| rd_data | output | DATA_W | Returned word |
| done | output | 1 | Last word of the run is returning |
| stall_cnt | output | CNT_W | Bank-conflict stall cycles of the run |

## Verification
The bench numbers every rising edge. From the start edge S it works out the issuing edge of each element as the later of two edges: one past the previous issue, and the edge at which that element's bank frees. The earliest first issue is S+1, and a bank's free edge is its last issue plus the occupancy. Each word is then expected in the cycle after edge issue+latency, and `done` is expected in the cycle of the last word. `stall_cnt` is expected to equal the final issue edge minus S minus the length. The bench samples all outputs on the falling edge and stamps each with the edge count. A word is accepted only when its stamp, data and element number all match. Ignored starts are checked by showing that the same run's stamps still match, or that no output moves for several cycles.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
   localparam logic [31:0] FILL_MUL = 32'd40503;
   localparam logic [31:0] FILL_XOR = 32'hC3A5_0F1E;

   function automatic logic [31:0] vbs_fill(input logic [31:0] a);
      logic [31:0] p;
      p = a * FILL_MUL;
      return p ^ FILL_XOR;
   endfunction
endpackage

// File: rtl/vbs_seq.sv
module vbs_seq #(
   parameter int ADDR_W = 10,
   parameter int LEN_W  = 7,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   input  logic [LEN_W-1:0]  len,
   input  logic              fire,
   output logic              gen_valid,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr,
   output logic              is_last
);
   logic [ADDR_W-1:0] stride_r;
   logic [LEN_W-1:0]  len_r;

   assign is_last = (LEN_W'(idx) == len_r - LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_valid <= 1'b0;
         idx       <= '0;
         addr      <= '0;
         stride_r  <= '0;
         len_r     <= '0;
      end else if (accept) begin
         gen_valid <= 1'b1;
         idx       <= '0;
         addr      <= base;
         stride_r  <= stride;
         len_r     <= len;
      end else if (fire) begin
         if (is_last) gen_valid <= 1'b0;
         idx  <= idx + IDX_W'(1);
         addr <= addr + stride_r;
      end
   end

   // R12: a stalled request holds its element and address
   p_hold_on_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      gen_valid && !fire && !accept |=> gen_valid && $stable(idx) && $stable(addr));

   // R2: the element number stays below the run length
   p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      gen_valid |-> LEN_W'(idx) < len_r);
endmodule

// File: rtl/vbs_bank.sv
module vbs_bank #(
   parameter int ADDR_W    = 10,
   parameter int BANK_W    = 3,
   parameter int DATA_W    = 32,
   parameter int BUSY_W    = 4,
   parameter int NUM_BANKS = 8,
   parameter int BANK_ID   = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     iss,
   input  logic [BUSY_W-1:0]        busy_val,
   input  logic [ADDR_W-BANK_W-1:0] rd_off,
   output logic                     free,
   output logic [DATA_W-1:0]        rd_word
);
   localparam int OFF_W = ADDR_W - BANK_W;
   localparam int DEPTH = 1 << OFF_W;

   logic [BUSY_W-1:0] cnt;
   logic [DATA_W-1:0] mem [DEPTH];

   assign free    = (cnt == '0);
   assign rd_word = mem[rd_off];

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (iss)        cnt <= busy_val - BUSY_W'(1);
      else if (cnt != '0)  cnt <= cnt - BUSY_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++)
            mem[k] <= DATA_W'(vbs_pkg::vbs_fill(32'(k) * 32'(NUM_BANKS) + 32'(BANK_ID)));
      end
   end

   // R4: no issue reaches a bank whose countdown is still running
   p_issue_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss |-> cnt == '0);

   // R4: an issue loads occupancy minus one
   p_busy_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss |=> cnt == $past(busy_val) - BUSY_W'(1));
endmodule

// File: rtl/vbs_ret.sv
module vbs_ret #(
   parameter int MAX_LAT = 8,
   parameter int LAT_W   = 4,
   parameter int IDX_W   = 6,
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LAT_W-1:0]  lat,
   input  logic              iss,
   input  logic [IDX_W-1:0]  iss_idx,
   input  logic [ADDR_W-1:0] iss_addr,
   input  logic              iss_last,
   output logic [ADDR_W-1:0] tap_addr,
   input  logic [DATA_W-1:0] tap_word,
   output logic              rd_valid,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last
);
   localparam int TAP_W = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

   logic              st_v    [MAX_LAT];
   logic              st_last [MAX_LAT];
   logic [IDX_W-1:0]  st_idx  [MAX_LAT];
   logic [ADDR_W-1:0] st_addr [MAX_LAT];
   logic [TAP_W-1:0]  tap;

   assign tap      = TAP_W'(lat - LAT_W'(1));
   assign tap_addr = st_addr[tap];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < MAX_LAT; k++) begin
            st_v[k]    <= 1'b0;
            st_last[k] <= 1'b0;
            st_idx[k]  <= '0;
            st_addr[k] <= '0;
         end
      end else begin
         st_v[0]    <= iss;
         st_last[0] <= iss && iss_last;
         st_idx[0]  <= iss_idx;
         st_addr[0] <= iss_addr;
         for (int k = 1; k < MAX_LAT; k++) begin
            st_v[k]    <= st_v[k-1];
            st_last[k] <= st_last[k-1];
            st_idx[k]  <= st_idx[k-1];
            st_addr[k] <= st_addr[k-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_last  <= 1'b0;
         rd_idx   <= '0;
         rd_data  <= '0;
      end else begin
         rd_valid <= st_v[tap];
         rd_last  <= st_v[tap] && st_last[tap];
         rd_idx   <= st_idx[tap];
         rd_data  <= tap_word;
      end
   end

   // R10: the end marker only travels with a returned word
   p_done_with_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);
endmodule

// File: rtl/vec_bank_sched.sv
module vec_bank_sched #(
   parameter int NUM_BANKS = 8,
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 32,
   parameter int MAX_LEN   = 64,
   parameter int MAX_LAT   = 8,
   parameter int MAX_BUSY  = 8,
   parameter int CNT_W     = 16,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int LEN_W    = $clog2(MAX_LEN + 1),
   localparam int IDX_W    = $clog2(MAX_LEN),
   localparam int LAT_W    = $clog2(MAX_LAT + 1),
   localparam int BUSY_W   = $clog2(MAX_BUSY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] st_base,
   input  logic [ADDR_W-1:0] st_stride,
   input  logic [LEN_W-1:0]  st_len,
   input  logic [LAT_W-1:0]  st_lat,
   input  logic [BUSY_W-1:0] st_busy,
   output logic              active,
   output logic              req_valid,
   output logic              req_ready,
   output logic [IDX_W-1:0]  req_idx,
   output logic [BANK_W-1:0] req_bank,
   output logic              rd_valid,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic [CNT_W-1:0]  stall_cnt
);
   localparam int OFF_W = ADDR_W - BANK_W;

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data
      $error("DATA_W must lie in 1..32");
   end
   if (ADDR_W <= BANK_W || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must exceed the bank bits and stay small");
   end
   if (MAX_LEN < 2 || MAX_LAT < 1 || MAX_BUSY < 1) begin : g_bad_limits
      $error("length, latency and occupancy limits out of range");
   end

   logic              accept, fire, is_last, done_w;
   logic [ADDR_W-1:0] gen_addr, tap_addr;
   logic [LAT_W-1:0]  lat_r;
   logic [BUSY_W-1:0] busy_r;
   logic [NUM_BANKS-1:0] bank_free;
   logic [DATA_W-1:0] bank_word [NUM_BANKS];

   assign accept = start && !active && (st_len != '0) && (st_len <= LEN_W'(MAX_LEN));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         lat_r  <= LAT_W'(1);
         busy_r <= BUSY_W'(1);
      end else if (accept) begin
         active <= 1'b1;
         lat_r  <= (st_lat == '0) ? LAT_W'(1) :
                   (st_lat > LAT_W'(MAX_LAT)) ? LAT_W'(MAX_LAT) : st_lat;
         busy_r <= (st_busy == '0) ? BUSY_W'(1) :
                   (st_busy > BUSY_W'(MAX_BUSY)) ? BUSY_W'(MAX_BUSY) : st_busy;
      end else if (done_w) begin
         active <= 1'b0;
      end
   end

   vbs_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .accept(accept), .base(st_base),
      .stride(st_stride), .len(st_len), .fire(fire), .gen_valid(req_valid),
      .idx(req_idx), .addr(gen_addr), .is_last(is_last)
   );

   assign req_bank  = gen_addr[BANK_W-1:0];
   assign req_ready = bank_free[req_bank];
   assign fire      = req_valid && req_ready;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      vbs_bank #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W),
                 .BUSY_W(BUSY_W), .NUM_BANKS(NUM_BANKS), .BANK_ID(b)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .iss(fire && (req_bank == BANK_W'(b))),
         .busy_val(busy_r), .rd_off(tap_addr[ADDR_W-1:BANK_W]),
         .free(bank_free[b]), .rd_word(bank_word[b])
      );
   end

   vbs_ret #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W), .IDX_W(IDX_W),
             .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ret (
      .clk(clk), .rst_n(rst_n), .lat(lat_r), .iss(fire), .iss_idx(req_idx),
      .iss_addr(gen_addr), .iss_last(is_last), .tap_addr(tap_addr),
      .tap_word(bank_word[tap_addr[BANK_W-1:0]]), .rd_valid(rd_valid),
      .rd_idx(rd_idx), .rd_data(rd_data), .rd_last(done_w)
   );

   assign done = done_w;

   always_ff @(posedge clk) begin
      if (!rst_n)                                   stall_cnt <= '0;
      else if (accept)                              stall_cnt <= '0;
      else if (req_valid && !req_ready && stall_cnt != '1)
         stall_cnt <= stall_cnt + CNT_W'(1);
   end

   // R11: a start during a run leaves the run's timing values alone
   p_ignore_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      active && start |=> $stable(lat_r) && $stable(busy_r));

   // R10: the run ends on the cycle after the last word
   p_end_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !active);

   // R9: the stall count only moves while a request waits
   p_stall_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid && !start |=> $stable(stall_cnt));
endmodule

// File: tb/sim_vec_bank_sched.sv
`timescale 1ns/1ps
module sim_vec_bank_sched;
   localparam int NB = 8;
   localparam int AW = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [9:0]  st_base = '0;
   logic [9:0]  st_stride = '0;
   logic [6:0]  st_len = '0;
   logic [3:0]  st_lat = '0;
   logic [3:0]  st_busy = '0;
   logic        active, req_valid, req_ready, rd_valid, done;
   logic [5:0]  req_idx, rd_idx;
   logic [2:0]  req_bank;
   logic [31:0] rd_data;
   logic [15:0] stall_cnt;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   int got_n = 0;
   int got_idx [64];
   int got_cyc [64];
   logic [31:0] got_dat [64];
   bit done_seen = 0;
   int done_cyc = 0;
   int bank_free_at [NB];

   always #2 clk = ~clk;

   vec_bank_sched u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .st_base(st_base),
      .st_stride(st_stride), .st_len(st_len), .st_lat(st_lat), .st_busy(st_busy),
      .active(active), .req_valid(req_valid), .req_ready(req_ready),
      .req_idx(req_idx), .req_bank(req_bank), .rd_valid(rd_valid),
      .rd_idx(rd_idx), .rd_data(rd_data), .done(done), .stall_cnt(stall_cnt)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rd_valid && got_n < 64) begin
         got_idx[got_n] = int'(rd_idx);
         got_cyc[got_n] = cyc;
         got_dat[got_n] = rd_data;
         got_n = got_n + 1;
      end
      if (done && !done_seen) begin
         done_seen = 1;
         done_cyc = cyc;
      end
   end

   function automatic logic [31:0] word_at(input int a);
      logic [31:0] p;
      p = 32'(a) * 32'd40503;
      return p ^ 32'hC3A5_0F1E;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   // one vector load, compared against a model of the issue schedule
   task automatic run_op(input int base, input int stride, input int len,
                         input int lat, input int busy, input string tag,
                         input bit inject);
      int s, prev, e, a, b, le, be, last_issue;
      int exp_cyc [64];
      logic [31:0] exp_dat [64];
      le = (lat == 0) ? 1 : lat;
      be = (busy == 0) ? 1 : busy;
      got_n = 0;
      done_seen = 0;
      @(negedge clk);
      st_base = 10'(base); st_stride = 10'(stride); st_len = 7'(len);
      st_lat = 4'(lat); st_busy = 4'(busy); start = 1'b1;
      s = cyc + 1;
      prev = s;
      for (int i = 0; i < len; i++) begin
         a = (base + i * stride) & ((1 << AW) - 1);
         b = a % NB;
         e = prev + 1;
         if (bank_free_at[b] > e) e = bank_free_at[b];
         bank_free_at[b] = e + be;
         prev = e;
         exp_cyc[i] = e + le;
         exp_dat[i] = word_at(a);
      end
      last_issue = prev;
      @(negedge clk);
      start = 1'b0;
      check(req_valid == 1'b1, "R12", "request pending after start", req_valid, 1);
      if (inject) begin
         repeat (2) @(negedge clk);
         st_base = 10'd5; st_stride = 10'd1; st_len = 7'd3;
         st_lat = 4'd1; st_busy = 4'd1; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done_seen) @(posedge clk);
      @(negedge clk);
      check(active == 1'b0, "R10", "active after done", active, 0);
      check(got_n == len, "R2", "word count", got_n, len);
      for (int i = 0; i < len && i < got_n; i++) begin
         check(got_idx[i] == i, "R6", "element order", got_idx[i], i);
         check(got_cyc[i] == exp_cyc[i], tag, "return cycle", got_cyc[i], exp_cyc[i]);
         check(got_dat[i] == exp_dat[i], "R3", "word value", got_dat[i], exp_dat[i]);
      end
      check(done_cyc == exp_cyc[len-1], "R10", "done cycle", done_cyc, exp_cyc[len-1]);
      check(int'(stall_cnt) == last_issue - s - len, "R9", "stall count",
            stall_cnt, last_issue - s - len);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(active == 1'b0, "R1", "active", active, 0);
      check(req_valid == 1'b0, "R1", "req_valid", req_valid, 0);
      check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
      check(rd_valid == 1'b0, "R1", "rd_valid", rd_valid, 0);
      check(done == 1'b0, "R1", "done", done, 0);
      check(stall_cnt == 16'd0, "R1", "stall_cnt", stall_cnt, 0);
   endtask

   task automatic t_bad_len(input int len);
      int moved;
      moved = 0;
      @(negedge clk);
      st_base = 10'd0; st_stride = 10'd1; st_len = 7'(len);
      st_lat = 4'd2; st_busy = 4'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 10; k++) begin
         if (active || req_valid || rd_valid || done) moved++;
         @(negedge clk);
      end
      check(moved == 0, "R11", "cycles with activity after rejected length", moved, 0);
   endtask

   initial begin
      for (int b = 0; b < NB; b++) bank_free_at[b] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      run_op(3, 1, 16, 3, 1, "R12", 0);
      run_op(2, 8, 12, 5, 2, "R5", 0);
      run_op(7, 8, 10, 2, 4, "R8", 0);
      run_op(1, 4, 20, 3, 3, "R7", 0);
      run_op(9, 1020, 64, 0, 3, "R4", 0);
      run_op(100, 3, 40, 4, 2, "R11", 1);
      t_bad_len(0);
      t_bad_len(65);
      run_op(600, 1, 1, 8, 8, "R5", 0);
      finish_run();
   end
endmodule